// File: doc/BRIEF.md
# I2C Operating-Mode State Controller

This block holds the two status bits that tell an I2C controller which of its four operating modes it is in. The role bit picks master (1) or slave (0), and the direction bit picks transmit (1) or receive (0). The bits update on their own when single-cycle event pulses arrive from the neighbouring logic. These pulses come from the bus-condition detectors, the address-byte sender and the slave address comparator. Software can force the bits through a write port, but only while a write-unlock input is high.

The block also keeps a bus-busy flag and two latched requests internally: one for issuing a start and one for issuing a restart. The bus events use these to decide what a detected start condition means. All outputs come straight from flops, so an event pulse sampled at one rising edge appears on the outputs right after that edge. All event and control pins are plain level or pulse signals. No data stream passes through the block, so it has no valid/ready handshake.

Top module: `i2c_mode_ctrl`

## Requirements
- R1: A low `rst_n` or a high `soft_rst_i` clears both mode bits, the bus-busy flag and both pending requests. `soft_rst_i` outranks every other input in the same cycle.
- R2: `mode_o` is `{role_o, dir_o}`, with these encodings: 2'b00 slave receive, 2'b01 slave transmit, 2'b10 master receive, 2'b11 master transmit.
- R3: `start_req_i` latches a start request. A start detected while that request is pending sets both bits (master transmit) and uses up the request. A later start with no new request does not make the block master.
- R4: `rstart_req_i` latches a restart request. A start detected while only that request is pending sets the direction bit, leaves the role bit unchanged, and uses up the request.
- R5: When the role bit is 1, `addr_tx_i` sets the direction bit to the inverse of `addr_rw_i`: R/W 0 gives transmit and R/W 1 gives receive. When the role bit is 0, the pulse has no effect.
- R6: When the role bit is 0, `slv_match_i` loads the direction bit from `slv_rw_i`. `gcall_i` (general-call match) always loads receive. When the role bit is 1, both pulses have no effect.
- R7: When the role bit is 0, a start detected while the bus is busy and no request is pending is a restart seen as a slave. It clears the direction bit.
- R8: `stop_det_i` clears both bits and the busy flag. It outranks every bus event and CPU write in the same cycle.
- R9: `arb_lost_i` clears both bits. It outranks every bus event and CPU write in the same cycle.
- R10: When `cpu_wr_i` and `wr_unlock_i` are both high, the block loads role from `cpu_wdata_i[1]` and direction from `cpu_wdata_i[0]`. When `wr_unlock_i` is low, the write is ignored. For each bit, a bus event that updates the bit in the same cycle wins over the write.
- R11: Any detected start sets the internal busy flag. Stop and reset clear it. The busy flag decides R7, so it is observed through the mode outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst_i | input | 1 | Module soft reset pulse |
| start_req_i | input | 1 | Pulse: software asks for a start condition |
| rstart_req_i | input | 1 | Pulse: software asks for a restart condition |
| start_det_i | input | 1 | Pulse: start condition seen on the bus |
| stop_det_i | input | 1 | Pulse: stop condition seen on the bus |
| arb_lost_i | input | 1 | Pulse: arbitration-lost flag being set |
| addr_tx_i | input | 1 | Pulse: address byte sent as master |
| addr_rw_i | input | 1 | R/W bit of the sent address byte |
| slv_match_i | input | 1 | Pulse: received address matched an own slave address |
| slv_rw_i | input | 1 | R/W bit received with the matched address |
| gcall_i | input | 1 | Pulse: general-call address matched |
| cpu_wr_i | input | 1 | CPU write strobe for the mode bits |
| cpu_wdata_i | input | 2 | CPU write data: bit 1 role, bit 0 direction |
| wr_unlock_i | input | 1 | Write-protect release; a CPU write takes effect only while high |
| role_o | output | 1 | 1 master, 0 slave |
| dir_o | output | 1 | 1 transmit, 0 receive |
| mode_o | output | 2 | Four-way operating mode `{role, dir}` |

## Verification
The bench targets the priority collisions:
- Arbitration loss arriving together with a start that would make the block master. A wrong ordering would leave it master after losing the bus.
- A soft reset together with an unlocked CPU write.
- A bus address event and a CPU write landing on the same cycle. A design with whole-word priority instead of per-bit priority would lose the role bit.

It also checks that a start request is used up once, and that a start with no request leaves the block slave. A design that kept the request would make the block master on every start.

The slave restart case is driven with the busy flag both set and cleared, including just after a soft reset. A busy flag that was not cleared would wrongly drop the direction bit. Every clock is compared against a behavioural model, so a locked write or an out-of-role address pulse that leaked through shows up at once.

// File: rtl/i2c_mode_pkg.sv
package i2c_mode_pkg;
  localparam int MODE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_SLV_RX = 2'b00,
    MODE_SLV_TX = 2'b01,
    MODE_MST_RX = 2'b10,
    MODE_MST_TX = 2'b11
  } op_mode_e;

  // role: 1 master / 0 slave ; dir: 1 transmit / 0 receive
  typedef struct packed {
    logic role;
    logic dir;
  } mode_bits_t;

  // per-bit update request produced by the bus-event decoder
  typedef struct packed {
    logic role_we;
    logic role_val;
    logic dir_we;
    logic dir_val;
  } mode_upd_t;
endpackage

// File: rtl/i2c_mode_busmon.sv
module i2c_mode_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic soft_rst,
  input  logic start_req,
  input  logic rstart_req,
  input  logic start_det,
  input  logic stop_det,
  output logic start_pend,
  output logic rstart_pend,
  output logic busy
);
  // requests: a detected start consumes the old request, a new one in the same cycle stays
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_pend  <= 1'b0;
      rstart_pend <= 1'b0;
      busy        <= 1'b0;
    end else if (soft_rst) begin
      start_pend  <= 1'b0;
      rstart_pend <= 1'b0;
      busy        <= 1'b0;
    end else begin
      start_pend  <= start_req  | (start_pend  & ~start_det);
      rstart_pend <= rstart_req | (rstart_pend & ~start_det);
      if (stop_det)       busy <= 1'b0;
      else if (start_det) busy <= 1'b1;
    end
  end
endmodule

// File: rtl/i2c_mode_evt.sv
module i2c_mode_evt
  import i2c_mode_pkg::*;
#(
  parameter bit GCALL_EN = 1'b1
) (
  input  mode_bits_t cur,
  input  logic       start_pend,
  input  logic       rstart_pend,
  input  logic       busy,
  input  logic       start_det,
  input  logic       addr_tx,
  input  logic       addr_rw,
  input  logic       slv_match,
  input  logic       slv_rw,
  input  logic       gcall,
  output mode_upd_t  upd
);
  logic gc_hit;

  generate
    if (GCALL_EN) begin : g_gcall
      assign gc_hit = gcall;
    end else begin : g_no_gcall
      assign gc_hit = 1'b0;
    end
  endgenerate

  always_comb begin
    upd = '0;
    if (start_det && start_pend) begin
      upd.role_we  = 1'b1;
      upd.role_val = 1'b1;
      upd.dir_we   = 1'b1;
      upd.dir_val  = 1'b1;
    end else if (start_det && rstart_pend) begin
      upd.dir_we  = 1'b1;
      upd.dir_val = 1'b1;
    end else if (start_det && busy && !cur.role) begin
      upd.dir_we  = 1'b1;
      upd.dir_val = 1'b0;
    end else if (addr_tx && cur.role) begin
      upd.dir_we  = 1'b1;
      upd.dir_val = ~addr_rw;
    end else if ((slv_match || gc_hit) && !cur.role) begin
      upd.dir_we  = 1'b1;
      upd.dir_val = slv_rw & ~gc_hit;
    end
  end
endmodule

// File: rtl/i2c_mode_reg.sv
module i2c_mode_reg
  import i2c_mode_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       soft_rst,
  input  logic       clr,
  input  mode_upd_t  upd,
  input  logic       cpu_wr,
  input  logic       unlock,
  input  mode_bits_t cpu_wdata,
  output mode_bits_t q
);
  logic cpu_ok;
  assign cpu_ok = cpu_wr & unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (soft_rst || clr) begin
      q <= '0;
    end else begin
      if (upd.role_we)  q.role <= upd.role_val;
      else if (cpu_ok)  q.role <= cpu_wdata.role;
      if (upd.dir_we)   q.dir  <= upd.dir_val;
      else if (cpu_ok)  q.dir  <= cpu_wdata.dir;
    end
  end
endmodule

// File: rtl/i2c_mode_ctrl.sv
module i2c_mode_ctrl
  import i2c_mode_pkg::*;
#(
  parameter bit GCALL_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst_i,
  input  logic              start_req_i,
  input  logic              rstart_req_i,
  input  logic              start_det_i,
  input  logic              stop_det_i,
  input  logic              arb_lost_i,
  input  logic              addr_tx_i,
  input  logic              addr_rw_i,
  input  logic              slv_match_i,
  input  logic              slv_rw_i,
  input  logic              gcall_i,
  input  logic              cpu_wr_i,
  input  logic [MODE_W-1:0] cpu_wdata_i,
  input  logic              wr_unlock_i,
  output logic              role_o,
  output logic              dir_o,
  output logic [MODE_W-1:0] mode_o
);
  logic       start_pend, rstart_pend, busy;
  mode_bits_t cur;
  mode_upd_t  upd;
  logic       role, dir;

  i2c_mode_busmon u_mon (
    .clk         (clk),
    .rst_n       (rst_n),
    .soft_rst    (soft_rst_i),
    .start_req   (start_req_i),
    .rstart_req  (rstart_req_i),
    .start_det   (start_det_i),
    .stop_det    (stop_det_i),
    .start_pend  (start_pend),
    .rstart_pend (rstart_pend),
    .busy        (busy)
  );

  i2c_mode_evt #(.GCALL_EN(GCALL_EN)) u_evt (
    .cur         (cur),
    .start_pend  (start_pend),
    .rstart_pend (rstart_pend),
    .busy        (busy),
    .start_det   (start_det_i),
    .addr_tx     (addr_tx_i),
    .addr_rw     (addr_rw_i),
    .slv_match   (slv_match_i),
    .slv_rw      (slv_rw_i),
    .gcall       (gcall_i),
    .upd         (upd)
  );

  i2c_mode_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_rst  (soft_rst_i),
    .clr       (stop_det_i | arb_lost_i),
    .upd       (upd),
    .cpu_wr    (cpu_wr_i),
    .unlock    (wr_unlock_i),
    .cpu_wdata (mode_bits_t'(cpu_wdata_i)),
    .q         (cur)
  );

  assign role   = cur.role;
  assign dir    = cur.dir;
  assign role_o = role;
  assign dir_o  = dir;
  assign mode_o = op_mode_e'(cur);
endmodule

// File: rtl/i2c_mode_chk.sv
module i2c_mode_chk (
  input logic clk,
  input logic rst_n,
  input logic soft_rst,
  input logic start_det,
  input logic stop_det,
  input logic arb_lost,
  input logic addr_tx,
  input logic slv_match,
  input logic gcall,
  input logic cpu_wr,
  input logic unlock,
  input logic start_pend,
  input logic rstart_pend,
  input logic busy,
  input logic role,
  input logic dir
);
  p_soft_rst_r1: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!role && !dir && !busy && !start_pend && !rstart_pend));

  p_start_master_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && start_pend && !soft_rst && !stop_det && !arb_lost) |=> (role && dir));

  p_slave_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && busy && !role && !start_pend && !rstart_pend && !cpu_wr &&
     !soft_rst && !stop_det && !arb_lost) |=> (!role && !dir));

  p_stop_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (!role && !dir && !busy));

  p_arb_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arb_lost |=> (!role && !dir));

  p_locked_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !unlock && !soft_rst && !start_det && !stop_det && !arb_lost &&
     !addr_tx && !slv_match && !gcall) |=> $stable({role, dir}));

  p_busy_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !stop_det && !soft_rst) |=> busy);
endmodule

bind i2c_mode_ctrl i2c_mode_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .soft_rst    (soft_rst_i),
  .start_det   (start_det_i),
  .stop_det    (stop_det_i),
  .arb_lost    (arb_lost_i),
  .addr_tx     (addr_tx_i),
  .slv_match   (slv_match_i),
  .gcall       (gcall_i),
  .cpu_wr      (cpu_wr_i),
  .unlock      (wr_unlock_i),
  .start_pend  (start_pend),
  .rstart_pend (rstart_pend),
  .busy        (busy),
  .role        (role),
  .dir         (dir)
);

// File: tb/sim_i2c_mode_ctrl.sv
`timescale 1ns/1ps
module sim_i2c_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst_i = 0, start_req_i = 0, rstart_req_i = 0, start_det_i = 0;
  logic stop_det_i = 0, arb_lost_i = 0, addr_tx_i = 0, addr_rw_i = 0;
  logic slv_match_i = 0, slv_rw_i = 0, gcall_i = 0, cpu_wr_i = 0, wr_unlock_i = 0;
  logic [1:0] cpu_wdata_i = 2'b00;
  logic role_o, dir_o;
  logic [1:0] mode_o;

  int checks = 0;
  int errors = 0;
  string tag = "R1";
  bit done = 0;

  // behavioural reference state
  int m_role = 0, m_dir = 0, m_busy = 0, m_sreq = 0, m_rreq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_mode_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst_i(soft_rst_i),
    .start_req_i(start_req_i), .rstart_req_i(rstart_req_i),
    .start_det_i(start_det_i), .stop_det_i(stop_det_i), .arb_lost_i(arb_lost_i),
    .addr_tx_i(addr_tx_i), .addr_rw_i(addr_rw_i),
    .slv_match_i(slv_match_i), .slv_rw_i(slv_rw_i), .gcall_i(gcall_i),
    .cpu_wr_i(cpu_wr_i), .cpu_wdata_i(cpu_wdata_i), .wr_unlock_i(wr_unlock_i),
    .role_o(role_o), .dir_o(dir_o), .mode_o(mode_o)
  );

  always @(posedge clk or negedge rst_n) begin
    int nr, nd, nb, ns, nq;
    bit role_set, dir_set;
    if (!rst_n) begin
      m_role = 0; m_dir = 0; m_busy = 0; m_sreq = 0; m_rreq = 0;
    end else if (soft_rst_i) begin
      m_role = 0; m_dir = 0; m_busy = 0; m_sreq = 0; m_rreq = 0;
    end else begin
      nr = m_role; nd = m_dir; role_set = 0; dir_set = 0;
      ns = (start_req_i || (m_sreq != 0 && !start_det_i)) ? 1 : 0;
      nq = (rstart_req_i || (m_rreq != 0 && !start_det_i)) ? 1 : 0;
      nb = stop_det_i ? 0 : (start_det_i ? 1 : m_busy);
      if (stop_det_i || arb_lost_i) begin
        nr = 0; nd = 0;
      end else begin
        if (start_det_i && m_sreq != 0) begin
          nr = 1; nd = 1; role_set = 1; dir_set = 1;
        end else if (start_det_i && m_rreq != 0) begin
          nd = 1; dir_set = 1;
        end else if (start_det_i && m_busy != 0 && m_role == 0) begin
          nd = 0; dir_set = 1;
        end else if (addr_tx_i && m_role == 1) begin
          nd = addr_rw_i ? 0 : 1; dir_set = 1;
        end else if ((slv_match_i || gcall_i) && m_role == 0) begin
          nd = (slv_rw_i && !gcall_i) ? 1 : 0; dir_set = 1;
        end
        if (cpu_wr_i && wr_unlock_i) begin
          if (!role_set) nr = cpu_wdata_i[1];
          if (!dir_set)  nd = cpu_wdata_i[0];
        end
      end
      m_role = nr; m_dir = nd; m_busy = nb; m_sreq = ns; m_rreq = nq;
    end
  end

  // per-clock comparison against the model, away from the rising edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (role_o !== m_role[0] || dir_o !== m_dir[0] ||
          mode_o !== {m_role[0], m_dir[0]}) begin
        errors++;
        $display("FAIL %s model compare: actual mode=%b role=%b dir=%b expected mode=%b",
                 tag, mode_o, role_o, dir_o, {m_role[0], m_dir[0]});
      end
    end
  end

  task automatic cyc();
    @(negedge clk); #1;
    soft_rst_i = 0; start_req_i = 0; rstart_req_i = 0; start_det_i = 0;
    stop_det_i = 0; arb_lost_i = 0; addr_tx_i = 0; addr_rw_i = 0;
    slv_match_i = 0; slv_rw_i = 0; gcall_i = 0; cpu_wr_i = 0; wr_unlock_i = 0;
    cpu_wdata_i = 2'b00;
  endtask

  task automatic expect_mode(input string req, input logic [1:0] exp);
    checks++;
    if (mode_o !== exp || role_o !== exp[1] || dir_o !== exp[0]) begin
      errors++;
      $display("FAIL %s: actual mode=%b expected %b", req, mode_o, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] v, input logic unl);
    cpu_wr_i = 1; cpu_wdata_i = v; wr_unlock_i = unl;
    cyc();
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    rst_n = 1;
    cyc();
    tag = "R1"; expect_mode("R1 reset state", 2'b00);

    // R3 start request then start detected -> master transmit
    tag = "R3"; start_req_i = 1; cyc(); cyc();
    start_det_i = 1; cyc();
    expect_mode("R3 start with request", 2'b11);
    tag = "R2"; expect_mode("R2 encoding master tx", {1'b1, 1'b1});

    // R5 master address direction
    tag = "R5"; addr_tx_i = 1; addr_rw_i = 1; cyc();
    expect_mode("R5 addr rw=1 master rx", 2'b10);
    addr_tx_i = 1; addr_rw_i = 0; cyc();
    expect_mode("R5 addr rw=0 master tx", 2'b11);

    // R6 slave match ignored in master role
    tag = "R6"; slv_match_i = 1; slv_rw_i = 0; cyc();
    expect_mode("R6 match ignored as master", 2'b11);

    // R10 unlocked write, then R4 restart
    tag = "R10"; cpu_write(2'b10, 1'b1);
    expect_mode("R10 unlocked write", 2'b10);
    tag = "R4"; rstart_req_i = 1; cyc();
    start_det_i = 1; cyc();
    expect_mode("R4 restart sets dir", 2'b11);

    // R8 stop
    tag = "R8"; stop_det_i = 1; cyc();
    expect_mode("R8 stop clears", 2'b00);

    // R3 request consumed: start without request stays slave
    tag = "R3"; start_det_i = 1; cyc();
    expect_mode("R3 no request no master", 2'b00);

    // R6 slave matches, R7 slave restart
    tag = "R6"; slv_match_i = 1; slv_rw_i = 1; cyc();
    expect_mode("R6 slave match rw=1", 2'b01);
    tag = "R7"; start_det_i = 1; cyc();
    expect_mode("R7 slave restart clears dir", 2'b00);
    tag = "R6"; slv_match_i = 1; slv_rw_i = 1; cyc();
    gcall_i = 1; slv_rw_i = 1; cyc();
    expect_mode("R6 general call receive", 2'b00);
    slv_match_i = 1; slv_rw_i = 1; cyc();
    tag = "R5"; addr_tx_i = 1; addr_rw_i = 1; cyc();
    expect_mode("R5 addr ignored as slave", 2'b01);
    tag = "R8"; stop_det_i = 1; cyc();

    // R10 locked write ignored
    tag = "R10"; cpu_write(2'b11, 1'b0);
    expect_mode("R10 locked write ignored", 2'b00);
    cpu_write(2'b11, 1'b1);
    expect_mode("R10 unlocked write master tx", 2'b11);

    // R9 arbitration lost, alone and against a master start
    tag = "R9"; arb_lost_i = 1; cyc();
    expect_mode("R9 arb lost clears", 2'b00);
    start_req_i = 1; cyc();
    start_det_i = 1; arb_lost_i = 1; cyc();
    expect_mode("R9 arb lost beats start", 2'b00);
    stop_det_i = 1; cyc();

    // R10 per-bit priority: bus dir wins, cpu role applies
    tag = "R10"; cpu_write(2'b10, 1'b1);
    addr_tx_i = 1; addr_rw_i = 0; cpu_wr_i = 1; wr_unlock_i = 1; cpu_wdata_i = 2'b00; cyc();
    expect_mode("R10 bus beats cpu per bit", 2'b01);

    // R1 soft reset beats write; R11 busy cleared by soft reset
    tag = "R1"; start_det_i = 1; cyc();
    soft_rst_i = 1; cpu_wr_i = 1; wr_unlock_i = 1; cpu_wdata_i = 2'b11; cyc();
    expect_mode("R1 soft reset beats write", 2'b00);
    tag = "R11"; cpu_write(2'b01, 1'b1);
    start_det_i = 1; cyc();
    expect_mode("R11 busy cleared, start keeps dir", 2'b01);
    start_det_i = 1; cyc();
    expect_mode("R11 busy set, slave restart", 2'b00);

    // R8 stop beats set and write in same cycle
    tag = "R8"; start_req_i = 1; cyc();
    start_det_i = 1; stop_det_i = 1; cpu_wr_i = 1; wr_unlock_i = 1; cpu_wdata_i = 2'b11; cyc();
    expect_mode("R8 stop outranks all", 2'b00);

    // R1 async reset
    tag = "R1"; cpu_write(2'b11, 1'b1);
    rst_n = 0; #2;
    expect_mode("R1 async reset", 2'b00);
    @(negedge clk); #1 rst_n = 1;
    cyc();
    expect_mode("R1 after reset", 2'b00);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule